// File: doc/BRIEF.md
# Fully Associative LRU Tag Store

This block is a small tag array with a single set, in which any block address can sit in any of its entries. Each entry holds a tag, a valid bit and a recency rank, and the ranks always form a strict order from most recently used (rank 0) to least recently used (rank N-1). A requester presents a byte address and one of three operations. A lookup updates recency and allocates an entry on a miss. A probe only reports. An invalidate drops a matching entry.

Because the ranks of one LRU stack are exactly what a smaller LRU cache would hold, every hit also reports a residency mask. The mask tells which smaller power-of-two capacities (1, 2, 4, ... entries) would have hit on the same access. Per-capacity hit and miss counters and an access counter accumulate these results for lookups, so a single run sizes several caches at once. Data storage is not part of the block.

Top module: `lru_tag_store`

## Requirements
- R1: After reset every entry is invalid, ranks equal entry indices, all counters read zero, rsp_valid_o is low, and req_ready_o is high from the first clock after reset.
- R2: The tag is the address with its low log2(BLK_BYTES) offset bits dropped, so addresses that differ only in those bits hit the same entry; rsp_off_o returns those low bits and rsp_blk_o returns the block address rebuilt from the tag with a zero offset.
- R3: A lookup (op 2'b00) that hits sets the matching entry to rank 0, and every entry that was more recent than it moves down one rank.
- R4: A probe (op 2'b01, and the reserved op 2'b11) reports hit, way and mask but changes no rank, valid bit or counter.
- R5: A lookup miss installs the tag in the lowest-index invalid entry, or in the rank N-1 entry when all are valid; the new entry becomes valid with rank 0 and the evicted tag no longer hits.
- R6: rsp_mask_o bit i (i = 0 .. log2(N)-1) is set on a lookup or probe hit whose entry rank before the access is below 2^i; the mask is zero on every miss and on every invalidate.
- R7: Each accepted lookup adds one to acc_cnt_o and, for each capacity index c = 0 .. log2(N) (capacity 2^c entries, c = log2(N) being the full array), adds one to hit_cnt_o[c] if it hit with rank below 2^c and to miss_cnt_o[c] otherwise.
- R8: An invalidate (op 2'b10) clears the valid bit of the entry holding the tag, reports rsp_hit_o as whether one was found, and leaves ranks unchanged; later accesses to that tag miss.
- R9: Each accepted request yields exactly one response with rsp_valid_o high on the next cycle, and rsp_lat_o carries HIT_LAT.
- R10: While req_valid_i is low, no state or counter changes and rsp_valid_o stays low.
- R11: rsp_way_o is the hit entry on a hit, the allocated entry on a lookup miss, and 0 on a probe or invalidate miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 2 | 00 lookup, 01 probe, 10 invalidate, 11 probe |
| req_addr_i | input | ADDR_W | Byte address |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Tag was found in a valid entry |
| rsp_way_o | output | IDX_W | Entry index (see R11) |
| rsp_mask_o | output | LOG_N | Residency in smaller capacities |
| rsp_lat_o | output | LAT_W | Fixed hit latency |
| rsp_blk_o | output | ADDR_W | Block address from the tag |
| rsp_off_o | output | OFF_W | Offset within the block |
| acc_cnt_o | output | CNT_W | Lookup count |
| hit_cnt_o | output | NCAP x CNT_W | Hits per capacity |
| miss_cnt_o | output | NCAP x CNT_W | Misses per capacity |

## Verification
Victim choice and the recency shift of all other entries fall in the same cycle when a lookup misses with every entry valid. The LRU entry is evicted and re-ranked to 0 while all others age by one. The bench provokes this by filling the array, touching entries at mid ranks, then missing. It judges the result by the reported victim way, by a probe that misses on the evicted tag, and by the mask of a later probe on the entry that must now be least recent. Counter and rank updates also share a cycle, and the counters are compared against tallies built from the expected masks.

// File: rtl/lru_tag_pkg.sv
package lru_tag_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_PROBE  = 2'b01,
    OP_INVAL  = 2'b10,
    OP_RSVD   = 2'b11
  } lru_op_e;
endpackage

// File: rtl/lru_tag_match.sv
module lru_tag_match #(
  parameter int N     = 8,
  parameter int TAG_W = 28,
  parameter int IDX_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0][TAG_W-1:0]   tag_i,
  input  logic [N-1:0]              valid_i,
  input  logic [TAG_W-1:0]          key_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [N-1:0] match_vec;

  for (genvar j = 0; j < N; j++) begin : g_cmp
    assign match_vec[j] = valid_i[j] && (tag_i[j] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int j = 0; j < N; j++)
      if (match_vec[j]) idx_o = IDX_W'(j);
  end

  assign hit_o = |match_vec;

  // R5
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              valid_i,
  input  logic [N-1:0][IDX_W-1:0]   rank_i,
  output logic [IDX_W-1:0]          victim_o
);
  logic free_found;

  always_comb begin
    victim_o   = '0;
    free_found = 1'b0;
    for (int j = N - 1; j >= 0; j--) begin
      if (!valid_i[j]) begin
        victim_o   = IDX_W'(j);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int j = 0; j < N; j++)
        if (rank_i[j] == IDX_W'(N - 1)) victim_o = IDX_W'(j);
    end
  end

  // R5
  free_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_i) |-> !valid_i[victim_o]);

  // R5
  lru_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_i) |-> (rank_i[victim_o] == IDX_W'(N - 1)));
endmodule

// File: rtl/lru_rank_stack.sv
module lru_rank_stack #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      touch_i,
  input  logic [IDX_W-1:0]          touch_idx_i,
  output logic [N-1:0][IDX_W-1:0]   rank_o
);
  logic [N-1:0][IDX_W-1:0] rank_q;
  logic [IDX_W-1:0]        pivot;

  assign pivot  = rank_q[touch_idx_i];
  assign rank_o = rank_q;

  for (genvar j = 0; j < N; j++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank_q[j] <= IDX_W'(j);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(j))
          rank_q[j] <= '0;
        else if (rank_q[j] < pivot)
          rank_q[j] <= rank_q[j] + IDX_W'(1);
      end
    end
  end

  for (genvar v = 0; v < N; v++) begin : g_perm
    logic [N-1:0] holds_v;
    for (genvar j = 0; j < N; j++) begin : g_eq
      assign holds_v[j] = (rank_q[j] == IDX_W'(v));
    end
    // R3
    rank_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(holds_v) == 1);
  end

  // R3
  touch_to_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (rank_q[$past(touch_idx_i)] == '0));
endmodule

// File: rtl/lru_stats.sv
module lru_stats #(
  parameter int NCAP  = 4,
  parameter int IDX_W = 3,
  parameter int CNT_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        count_i,
  input  logic                        hit_i,
  input  logic [IDX_W-1:0]            rank_i,
  output logic [CNT_W-1:0]            acc_cnt_o,
  output logic [NCAP-1:0][CNT_W-1:0]  hit_cnt_o,
  output logic [NCAP-1:0][CNT_W-1:0]  miss_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_cnt_o <= '0;
    else if (count_i) acc_cnt_o <= acc_cnt_o + CNT_W'(1);
  end

  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    logic in_cap;
    assign in_cap = hit_i && (32'(rank_i) < (32'd1 << c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_cnt_o[c]  <= '0;
        miss_cnt_o[c] <= '0;
      end else if (count_i) begin
        if (in_cap) hit_cnt_o[c]  <= hit_cnt_o[c] + CNT_W'(1);
        else        miss_cnt_o[c] <= miss_cnt_o[c] + CNT_W'(1);
      end
    end

    // R7
    one_bucket_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_i |=> ((hit_cnt_o[c] != $past(hit_cnt_o[c])) !=
                   (miss_cnt_o[c] != $past(miss_cnt_o[c]))));
  end

  // R10
  idle_counts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_i |=> $stable(acc_cnt_o) && $stable(hit_cnt_o) && $stable(miss_cnt_o));
endmodule

// File: rtl/lru_tag_store.sv
module lru_tag_store
  import lru_tag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int N_ENTRIES = 8,
  parameter int CNT_W     = 16,
  parameter int HIT_LAT   = 2,
  parameter int LAT_W     = 4,
  parameter int IDX_W     = $clog2(N_ENTRIES),
  parameter int LOG_N     = $clog2(N_ENTRIES),
  parameter int OFF_W     = $clog2(BLK_BYTES),
  parameter int NCAP      = LOG_N + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [1:0]                  req_op_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_hit_o,
  output logic [IDX_W-1:0]            rsp_way_o,
  output logic [LOG_N-1:0]            rsp_mask_o,
  output logic [LAT_W-1:0]            rsp_lat_o,
  output logic [ADDR_W-1:0]           rsp_blk_o,
  output logic [OFF_W-1:0]            rsp_off_o,
  output logic [CNT_W-1:0]            acc_cnt_o,
  output logic [NCAP-1:0][CNT_W-1:0]  hit_cnt_o,
  output logic [NCAP-1:0][CNT_W-1:0]  miss_cnt_o
);
  localparam int N     = N_ENTRIES;
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [N-1:0][TAG_W-1:0]  tag_q;
  logic [N-1:0]             valid_q;
  logic [N-1:0][IDX_W-1:0]  rank;
  logic                     ready_q;
  lru_op_e                  op;
  lru_op_e                  rsp_op_q;
  logic                     fire, do_lk, do_pr, do_iv;
  logic [TAG_W-1:0]         key;
  logic                     m_hit;
  logic [IDX_W-1:0]         m_idx, victim, touch_idx, hit_rank;
  logic [LOG_N-1:0]         mask;

  assign op          = lru_op_e'(req_op_i);
  assign key         = req_addr_i[ADDR_W-1:OFF_W];
  assign req_ready_o = ready_q;
  assign fire        = req_valid_i && ready_q;
  assign do_lk       = fire && (op == OP_LOOKUP);
  assign do_iv       = fire && (op == OP_INVAL);
  assign do_pr       = fire && ((op == OP_PROBE) || (op == OP_RSVD));
  assign hit_rank    = rank[m_idx];
  assign touch_idx   = m_hit ? m_idx : victim;
  assign rsp_lat_o   = LAT_W'(HIT_LAT);

  lru_tag_match #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .clk_i, .rst_ni, .tag_i(tag_q), .valid_i(valid_q), .key_i(key),
    .hit_o(m_hit), .idx_o(m_idx)
  );

  lru_victim_pick #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk_i, .rst_ni, .valid_i(valid_q), .rank_i(rank), .victim_o(victim)
  );

  lru_rank_stack #(.N(N), .IDX_W(IDX_W)) u_rank (
    .clk_i, .rst_ni, .touch_i(do_lk), .touch_idx_i(touch_idx), .rank_o(rank)
  );

  lru_stats #(.NCAP(NCAP), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni, .count_i(do_lk), .hit_i(m_hit), .rank_i(hit_rank),
    .acc_cnt_o, .hit_cnt_o, .miss_cnt_o
  );

  // residency in the 2^i-entry prefix of the stack
  for (genvar i = 0; i < LOG_N; i++) begin : g_mask
    assign mask[i] = m_hit && (32'(hit_rank) < (32'd1 << i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      valid_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (do_lk && !m_hit) begin
        tag_q[victim]   <= key;
        valid_q[victim] <= 1'b1;
      end
      if (do_iv && m_hit) valid_q[m_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_mask_o  <= '0;
      rsp_blk_o   <= '0;
      rsp_off_o   <= '0;
      rsp_op_q    <= OP_PROBE;
    end else begin
      rsp_valid_o <= fire;
      if (fire) begin
        rsp_op_q   <= op;
        rsp_hit_o  <= m_hit;
        rsp_way_o  <= m_hit ? m_idx : (do_lk ? victim : '0);
        rsp_mask_o <= do_iv ? '0 : mask;
        rsp_blk_o  <= {(m_hit ? tag_q[m_idx] : key), {OFF_W{1'b0}}};
        rsp_off_o  <= req_addr_i[OFF_W-1:0];
      end
    end
  end

  // R3
  mru_after_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_op_q == OP_LOOKUP) |-> (rank[rsp_way_o] == '0) && valid_q[rsp_way_o]);

  // R4
  probe_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pr |=> $stable(rank) && $stable(valid_q) && $stable(tag_q));

  // R6
  mask_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_mask_o != '0) |-> rsp_hit_o && (rsp_op_q != OP_INVAL));

  for (genvar i = 0; i + 1 < LOG_N; i++) begin : g_thermo
    // R6
    mask_nested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_mask_o[i] |-> rsp_mask_o[i+1]);
  end

  // R8
  inval_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_iv && m_hit) |=> !valid_q[$past(m_idx)] && $stable(rank));

  // R9
  one_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);
endmodule

// File: tb/lru_tag_store_test.sv
module lru_tag_store_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCAP = 4;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic        hit;
    logic [2:0]  mask;
    logic [2:0]  way;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'h0000_0100, 1'b0, 3'b000, 3'd0},
    '{2'b00, 32'h0000_0200, 1'b0, 3'b000, 3'd1},
    '{2'b00, 32'h0000_0104, 1'b1, 3'b110, 3'd0},
    '{2'b01, 32'h0000_0208, 1'b1, 3'b110, 3'd1},
    '{2'b01, 32'h0000_0300, 1'b0, 3'b000, 3'd0},
    '{2'b00, 32'h0000_0200, 1'b1, 3'b110, 3'd1},
    '{2'b00, 32'h0000_0100, 1'b1, 3'b110, 3'd0},
    '{2'b10, 32'h0000_0200, 1'b1, 3'b000, 3'd1},
    '{2'b01, 32'h0000_0200, 1'b0, 3'b000, 3'd0},
    '{2'b00, 32'h0000_0400, 1'b0, 3'b000, 3'd1},
    '{2'b00, 32'h0000_010C, 1'b1, 3'b110, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [2:0] rsp_way, rsp_mask;
  logic [3:0] rsp_lat, rsp_off;
  logic [31:0] rsp_blk;
  logic [15:0] acc_cnt;
  logic [NCAP-1:0][15:0] hit_cnt, miss_cnt;

  int total = 0, bad = 0;
  int e_acc = 0;
  int e_hit [NCAP];
  int e_miss [NCAP];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_tag_store uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way),
    .rsp_mask_o(rsp_mask), .rsp_lat_o(rsp_lat), .rsp_blk_o(rsp_blk),
    .rsp_off_o(rsp_off), .acc_cnt_o(acc_cnt),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_counters(input string req);
    chk({req, " acc"}, 32'(acc_cnt), 32'(e_acc));
    for (int c = 0; c < NCAP; c++) begin
      chk($sformatf("%s hit_cnt[%0d]", req, c), 32'(hit_cnt[c]), 32'(e_hit[c]));
      chk($sformatf("%s miss_cnt[%0d]", req, c), 32'(miss_cnt[c]), 32'(e_miss[c]));
    end
  endtask

  // one request, response sampled at the next falling edge
  task automatic run(input logic [1:0] op, input logic [31:0] addr,
                     input logic ehit, input logic [2:0] emask, input logic [2:0] eway,
                     input string req);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " R9 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " R9 lat"}, 32'(rsp_lat), 32'd2);
    chk({req, " hit"}, 32'(rsp_hit), 32'(ehit));
    chk({req, " R6 mask"}, 32'(rsp_mask), 32'(emask));
    chk({req, " R11 way"}, 32'(rsp_way), 32'(eway));
    chk({req, " R2 off"}, 32'(rsp_off), 32'(addr[3:0]));
    if (ehit || op == 2'b00)
      chk({req, " R2 blk"}, rsp_blk, {addr[31:4], 4'h0});
    if (op == 2'b00) begin
      e_acc++;
      for (int c = 0; c < NCAP - 1; c++)
        if (emask[c]) e_hit[c]++; else e_miss[c]++;
      if (ehit) e_hit[NCAP-1]++; else e_miss[NCAP-1]++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCAP; c++) begin e_hit[c] = 0; e_miss[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk_counters("R1");
    run(2'b01, 32'h0000_0100, 1'b0, 3'b000, 3'd0, "R1 probe empty");
    chk_counters("R4 probe no count");

    // R10 idle cycles
    repeat (4) @(negedge clk);
    chk("R10 idle rsp_valid", 32'(rsp_valid), 32'd0);
    chk_counters("R10 idle");

    // vector table: R2 R3 R4 R5 R6 R8 R11
    for (int k = 0; k < NV; k++)
      run(VECS[k].op, VECS[k].addr, VECS[k].hit, VECS[k].mask, VECS[k].way,
          $sformatf("vec%0d R3/R5/R8", k));
    chk_counters("R7 after table");

    // reserved op behaves as probe (R4)
    run(2'b11, 32'h0000_0400, 1'b1, 3'b110, 3'd1, "R4 reserved op");

    // fill remaining entries (R5)
    for (int k = 1; k <= 6; k++)
      run(2'b00, 32'(k) << 12, 1'b0, 3'b000, 3'(k + 1), "R5 fill");

    // mid-rank hits (R3 R6)
    run(2'b00, 32'h0000_1000, 1'b1, 3'b000, 3'd2, "R6 rank5");
    run(2'b00, 32'h0000_5000, 1'b1, 3'b100, 3'd6, "R6 rank2");

    // full array miss evicts rank N-1 entry (R5)
    run(2'b00, 32'h0000_7000, 1'b0, 3'b000, 3'd1, "R5 evict lru");
    run(2'b01, 32'h0000_0400, 1'b0, 3'b000, 3'd0, "R5 evicted gone");
    run(2'b01, 32'h0000_0100, 1'b1, 3'b000, 3'd0, "R3 aged to lru");

    // invalidate miss changes nothing (R8)
    run(2'b10, 32'h0000_9000, 1'b0, 3'b000, 3'd0, "R8 inval miss");
    run(2'b01, 32'h0000_7000, 1'b1, 3'b111, 3'd1, "R8 mru intact");
    chk_counters("R7 final");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule